// File: doc/BRIEF.md
# Flash Line Buffer Prefetch Controller

This block sits between a bus read port and a slow flash array that returns whole 256-bit lines. Four line buffers, each tagged by line address, answer reads that hit a valid line. A read that misses starts a demand fill. The read is answered in the same cycle that the line comes back from flash.

After a miss, the block can fetch the next sequential lines ahead of use. A 3-bit limit selects how many such fetches are allowed in each miss epoch, and whether a buffer hit may start one. A buffer-enable input gates every buffer hit. Clearing it also wipes all buffer valid bits.

The flash side takes one line address at a time through a request/ready handshake. It raises a return strobe together with the line a fixed number of cycles after accepting the address. At most one flash access is outstanding. A demand miss always wins over a queued prefetch. A read whose line is already on its way from flash waits for that fill instead of fetching the line a second time.

Top module: `flash_prefetch_ctrl`

## Requirements
- R1: After reset the limit and enable inputs are expected at 0. With no read present, `flReq` stays low and no flash access occurs.
- R2: While `bufEnable` is 0, every read starts its own flash access. The read is answered from the returned line, and no prefetch is issued whatever the limit.
- R3: While `bufEnable` is 1, a read whose line is valid in a buffer gets `rdAck` in the same cycle, with no flash access. `rdData` is the 32-bit word at bits [32*w +: 32] of the line, where w = `rdAddr[2:0]`.
- R4: A miss with the flash idle is presented as `flReq` one cycle after the read appears. `rdAck` comes in the cycle `flRvalid` is high, which is latency+1 cycles after the read first appears.
- R5: Limit 3'b000 and the reserved value 3'b111 issue no prefetch.
- R6: Limit 3'b001 fetches line L+1 on a miss of line L. A buffer hit starts no prefetch.
- R7: Limits 3'b010, 3'b011, 3'b100 and 3'b101 allow 2, 3, 4 and 5 prefetches per miss epoch. The miss prefetches L+1, each later hit on line H prefetches H+1, and every hit or miss starts at most one prefetch.
- R8: Limit 3'b110 places no cap on the prefetches that follow a miss, still one per hit or miss.
- R9: Dropping `bufEnable` to 0 invalidates every buffer. After it returns to 1, a previously held line misses.
- R10: A fill goes into an invalid buffer if one exists. Otherwise it replaces the least recently used buffer, where both hits and fills count as use.
- R11: A demand miss is issued before a queued prefetch. A new miss restarts the epoch and replaces the queued prefetch target. A prefetch whose line is already held is dropped without being counted.
- R12: A read of a line that is being fetched stalls and is answered when that fill returns, with no second flash access.
- R13: `flAddr` is held stable while `flReq` is high and `flReady` is low, and `flReq` is never raised while an access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pfLimit | input | 3 | Prefetch limit code |
| bufEnable | input | 1 | Buffer enable; 0 invalidates all buffers |
| rdReq | input | 1 | Read request, held until `rdAck` |
| rdAddr | input | 16 | Word address of the read |
| rdAck | output | 1 | Read answered this cycle |
| rdData | output | 32 | Read data, valid with `rdAck` |
| flReq | output | 1 | Flash line request |
| flAddr | output | 13 | Flash line address |
| flReady | input | 1 | Flash accepts the request |
| flRvalid | input | 1 | Flash line return strobe |
| flLine | input | 256 | Returned flash line |

## Verification
A buffer hit must show `rdAck` in the cycle the read is presented. A miss on an idle flash must show it exactly latency+1 cycles later. The bench drives each read at a falling edge and samples `rdAck` at every later falling edge, so each response is compared against the cycle in which it is due. Prefetch effects can land several fills after the read that caused them. For that reason, flash accesses are counted only after a settle window long enough for every chained fill to finish. Stalled reads are checked to complete strictly before a fresh miss could.

// File: rtl/flp_pkg.sv
package flp_pkg;

  localparam int LIM_W = 3;
  localparam logic [LIM_W-1:0] LIM_OFF     = 3'd0;
  localparam logic [LIM_W-1:0] LIM_ONE     = 3'd1;
  localparam logic [LIM_W-1:0] LIM_HITMIN  = 3'd2;
  localparam logic [LIM_W-1:0] LIM_UNLIM   = 3'd6;
  localparam logic [LIM_W-1:0] LIM_RSVD    = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fillState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic alloc;     // claim a buffer for a new fill this cycle
    logic fillDone;  // flash line arrives this cycle
    logic fillKeep;  // keep the arriving line (buffers enabled)
    logic touchHit;  // a buffer hit is consumed this cycle
  } dpStrobe_t;

endpackage

// File: rtl/flp_datapath.sv
module flp_datapath
  import flp_pkg::*;
#(
  parameter int NUM_BUF     = 4,
  parameter int LINE_ADDR_W = 13,
  parameter int LINE_W      = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   bufEnable,
  input  dpStrobe_t              strb,
  input  logic [LINE_ADDR_W-1:0] lookupLine,
  input  logic [LINE_ADDR_W-1:0] pfLine,
  input  logic [LINE_ADDR_W-1:0] allocLine,
  input  logic [LINE_W-1:0]      fillData,
  output logic                   hit,
  output logic [LINE_W-1:0]      hitLine,
  output logic                   pfHeld
);

  localparam int SLOT_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam logic [SLOT_W-1:0] OLDEST = SLOT_W'(NUM_BUF - 1);

  logic [NUM_BUF-1:0]     validQ;
  logic [LINE_ADDR_W-1:0] tagQ  [NUM_BUF];
  logic [LINE_W-1:0]      dataQ [NUM_BUF];
  logic [SLOT_W-1:0]      ageQ  [NUM_BUF];
  logic [SLOT_W-1:0]      fillSlotQ;

  logic [NUM_BUF-1:0] lookMatch;
  logic [NUM_BUF-1:0] pfMatch;

  genvar g;
  generate
    for (g = 0; g < NUM_BUF; g++) begin : gSlot
      assign lookMatch[g] = validQ[g] && (tagQ[g] == lookupLine);
      assign pfMatch[g]   = validQ[g] && (tagQ[g] == pfLine);
    end
  endgenerate

  logic [SLOT_W-1:0] hitSlot;
  logic [SLOT_W-1:0] victim;
  logic              freeFound;

  always_comb begin
    hitSlot = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (lookMatch[i]) hitSlot = SLOT_W'(i);
    end
  end

  assign hit     = bufEnable && (|lookMatch);
  assign pfHeld  = |pfMatch;
  assign hitLine = dataQ[hitSlot];

  // Victim: lowest invalid buffer, otherwise the oldest one
  always_comb begin
    victim    = '0;
    freeFound = 1'b0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (!validQ[i] && !freeFound) begin
        victim    = SLOT_W'(i);
        freeFound = 1'b1;
      end
    end
    if (!freeFound) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (ageQ[i] == OLDEST) victim = SLOT_W'(i);
      end
    end
  end

  logic              touchEn;
  logic [SLOT_W-1:0] touchSlot;

  assign touchEn   = strb.alloc || strb.touchHit;
  assign touchSlot = strb.alloc ? victim : hitSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ    <= '0;
      fillSlotQ <= '0;
      for (int i = 0; i < NUM_BUF; i++) ageQ[i] <= SLOT_W'(i);
    end else begin
      if (touchEn) begin
        for (int i = 0; i < NUM_BUF; i++) begin
          if (SLOT_W'(i) == touchSlot)          ageQ[i] <= '0;
          else if (ageQ[i] < ageQ[touchSlot])   ageQ[i] <= ageQ[i] + 1'b1;
        end
      end
      if (strb.alloc) begin
        validQ[victim] <= 1'b0;
        fillSlotQ      <= victim;
      end
      if (strb.fillDone) validQ[fillSlotQ] <= strb.fillKeep;
      if (!bufEnable)    validQ <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.alloc)    tagQ[victim]     <= allocLine;
    if (strb.fillDone) dataQ[fillSlotQ] <= fillData;
  end

endmodule

// File: rtl/flp_control.sv
module flp_control
  import flp_pkg::*;
#(
  parameter int LINE_ADDR_W = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LIM_W-1:0]       pfLimit,
  input  logic                   bufEnable,
  input  logic                   rdReq,
  input  logic [LINE_ADDR_W-1:0] rdLine,
  input  logic                   bufHit,
  input  logic                   pfHeld,
  input  logic                   flReady,
  input  logic                   flRvalid,
  output dpStrobe_t              strb,
  output logic [LINE_ADDR_W-1:0] allocLine,
  output logic [LINE_ADDR_W-1:0] pfLine,
  output logic                   flReq,
  output logic [LINE_ADDR_W-1:0] flAddr,
  output logic                   rdAck,
  output logic                   ackFromBuf
);

  fillState_e             stateQ;
  logic [LINE_ADDR_W-1:0] fillLineQ;
  logic                   fillDemandQ;
  logic                   pfPendQ;
  logic [LINE_ADDR_W-1:0] pfLineQ;
  logic [LIM_W-1:0]       pfCountQ;

  logic inFlight, fillHitNow, bufAck, demandNeed;
  logic limOk, hitMode, belowCap, hitTrigger;
  logic startDemand, pfReady, startPf;

  assign inFlight   = (stateQ != ST_IDLE);
  assign bufAck     = rdReq && bufHit;
  assign fillHitNow = (stateQ == ST_WAIT) && flRvalid && rdReq && (rdLine == fillLineQ);
  assign demandNeed = rdReq && !bufHit && !(inFlight && (rdLine == fillLineQ));

  assign limOk    = (pfLimit != LIM_OFF) && (pfLimit != LIM_RSVD);
  assign hitMode  = (pfLimit >= LIM_HITMIN) && (pfLimit <= LIM_UNLIM);
  assign belowCap = (pfLimit == LIM_UNLIM) || (pfCountQ < pfLimit);

  // A hit (from a buffer or from a prefetch fill) may queue the next line
  assign hitTrigger = (bufAck || (fillHitNow && !fillDemandQ)) && hitMode && belowCap && bufEnable;

  assign startDemand = (stateQ == ST_IDLE) && demandNeed;
  assign pfReady     = (stateQ == ST_IDLE) && !demandNeed && !bufAck && pfPendQ &&
                       bufEnable && limOk && belowCap;
  assign startPf     = pfReady && !pfHeld;

  assign strb.alloc    = startDemand || startPf;
  assign strb.fillDone = (stateQ == ST_WAIT) && flRvalid;
  assign strb.fillKeep = bufEnable;
  assign strb.touchHit = bufAck;

  assign allocLine  = startDemand ? rdLine : pfLineQ;
  assign pfLine     = pfLineQ;
  assign flReq      = (stateQ == ST_REQ);
  assign flAddr     = fillLineQ;
  assign rdAck      = bufAck || fillHitNow;
  assign ackFromBuf = bufAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      fillLineQ   <= '0;
      fillDemandQ <= 1'b0;
      pfPendQ     <= 1'b0;
      pfLineQ     <= '0;
      pfCountQ    <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (startDemand || startPf) begin
          stateQ      <= ST_REQ;
          fillLineQ   <= allocLine;
          fillDemandQ <= startDemand;
        end
        ST_REQ:  if (flReady)  stateQ <= ST_WAIT;
        ST_WAIT: if (flRvalid) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase

      if (startDemand) begin
        pfCountQ <= '0;
      end else if (startPf && (pfCountQ != LIM_RSVD)) begin
        pfCountQ <= pfCountQ + 1'b1;
      end

      if (!bufEnable) begin
        pfPendQ <= 1'b0;
      end else if (startDemand) begin
        pfPendQ <= limOk;
        pfLineQ <= rdLine + 1'b1;
      end else if (hitTrigger) begin
        pfPendQ <= 1'b1;
        pfLineQ <= rdLine + 1'b1;
      end else if (pfReady) begin
        pfPendQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/flash_prefetch_ctrl.sv
module flash_prefetch_ctrl
  import flp_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int WORD_W         = 32,
  parameter int WORDS_PER_LINE = 8,
  parameter int NUM_BUF        = 4
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic [2:0]                                pfLimit,
  input  logic                                      bufEnable,
  input  logic                                      rdReq,
  input  logic [ADDR_W-1:0]                         rdAddr,
  output logic                                      rdAck,
  output logic [WORD_W-1:0]                         rdData,
  output logic                                      flReq,
  output logic [ADDR_W-$clog2(WORDS_PER_LINE)-1:0]  flAddr,
  input  logic                                      flReady,
  input  logic                                      flRvalid,
  input  logic [WORD_W*WORDS_PER_LINE-1:0]          flLine
);

  localparam int OFF_W       = $clog2(WORDS_PER_LINE);
  localparam int LINE_ADDR_W = ADDR_W - OFF_W;
  localparam int LINE_W      = WORD_W * WORDS_PER_LINE;

  dpStrobe_t              strb;
  logic [LINE_ADDR_W-1:0] rdLine, allocLine, pfLine;
  logic [OFF_W-1:0]       rdOff;
  logic                   bufHit, pfHeld, ackFromBuf;
  logic [LINE_W-1:0]      hitLine, srcLine;

  assign rdLine = rdAddr[ADDR_W-1:OFF_W];
  assign rdOff  = rdAddr[OFF_W-1:0];

  flp_control #(.LINE_ADDR_W(LINE_ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pfLimit(pfLimit), .bufEnable(bufEnable),
    .rdReq(rdReq), .rdLine(rdLine), .bufHit(bufHit), .pfHeld(pfHeld),
    .flReady(flReady), .flRvalid(flRvalid), .strb(strb),
    .allocLine(allocLine), .pfLine(pfLine), .flReq(flReq), .flAddr(flAddr),
    .rdAck(rdAck), .ackFromBuf(ackFromBuf)
  );

  flp_datapath #(.NUM_BUF(NUM_BUF), .LINE_ADDR_W(LINE_ADDR_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .bufEnable(bufEnable), .strb(strb),
    .lookupLine(rdLine), .pfLine(pfLine), .allocLine(allocLine),
    .fillData(flLine), .hit(bufHit), .hitLine(hitLine), .pfHeld(pfHeld)
  );

  assign srcLine = ackFromBuf ? hitLine : flLine;
  assign rdData  = srcLine[rdOff*WORD_W +: WORD_W];

endmodule

// File: rtl/flp_checker.sv
module flp_checker #(
  parameter int ADDR_W         = 16,
  parameter int WORDS_PER_LINE = 8
) (
  input logic                                     clk,
  input logic                                     rstN,
  input logic [2:0]                               pfLimit,
  input logic                                     bufEnable,
  input logic                                     rdReq,
  input logic [ADDR_W-1:0]                        rdAddr,
  input logic                                     rdAck,
  input logic                                     flReq,
  input logic [ADDR_W-$clog2(WORDS_PER_LINE)-1:0] flAddr,
  input logic                                     flReady,
  input logic                                     flRvalid
);

  localparam int OFF_W = $clog2(WORDS_PER_LINE);

  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rstN)                  outstanding <= 1'b0;
    else if (flReq && flReady)  outstanding <= 1'b1;
    else if (flRvalid)          outstanding <= 1'b0;
  end

  a_r13_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    flReq && !flReady |=> flReq && $stable(flAddr));

  a_r13_single_access: assert property (@(posedge clk) disable iff (!rstN)
    flReq |-> !outstanding);

  a_r2_disabled_from_flash: assert property (@(posedge clk) disable iff (!rstN)
    (!bufEnable && rdAck) |-> flRvalid);

  a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |-> rdReq);

  a_r5_no_prefetch: assert property (@(posedge clk) disable iff (!rstN)
    (flReq && flReady && (pfLimit == 3'd0 || pfLimit == 3'd7)) |->
      (rdReq && flAddr == rdAddr[ADDR_W-1:OFF_W]));

endmodule

bind flash_prefetch_ctrl flp_checker #(.ADDR_W(ADDR_W), .WORDS_PER_LINE(WORDS_PER_LINE)) u_chk (
  .clk(clk), .rstN(rstN), .pfLimit(pfLimit), .bufEnable(bufEnable),
  .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .flReq(flReq),
  .flAddr(flAddr), .flReady(flReady), .flRvalid(flRvalid)
);

// File: tb/sim_flash_prefetch_ctrl.sv
`timescale 1ns/100ps
module sim_flash_prefetch_ctrl;

  localparam int LAT    = 4;
  localparam int SETTLE = 40;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   pfLimit = 3'd0;
  logic         bufEnable = 1'b0;
  logic         rdReq = 1'b0;
  logic [15:0]  rdAddr = '0;
  logic         rdAck;
  logic [31:0]  rdData;
  logic         flReq;
  logic [12:0]  flAddr;
  logic         flReady, flRvalid;
  logic [255:0] flLine;

  int compared = 0;
  int mismatched = 0;
  int accCount = 0;
  int cnt = 0;
  logic [12:0] flAddrQ = '0;

  always #2.5 clk = ~clk;

  flash_prefetch_ctrl u0 (
    .clk(clk), .rstN(rstN), .pfLimit(pfLimit), .bufEnable(bufEnable),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
    .flReq(flReq), .flAddr(flAddr), .flReady(flReady), .flRvalid(flRvalid),
    .flLine(flLine)
  );

  // Flash model: one access at a time, line returned LAT cycles after accept
  assign flReady  = (cnt == 0);
  assign flRvalid = (cnt == 1);
  always_comb begin
    for (int w = 0; w < 8; w++) flLine[32*w +: 32] = {8'h5A, 5'd0, 3'(w), 3'd0, flAddrQ};
  end
  always @(posedge clk) begin
    if (!rstN) cnt <= 0;
    else if (flReq && flReady) begin
      cnt      <= LAT;
      flAddrQ  <= flAddr;
      accCount <= accCount + 1;
    end else if (cnt > 0) cnt <= cnt - 1;
  end

  function automatic logic [31:0] expWord(logic [12:0] line, logic [2:0] word);
    return {8'h5A, 5'd0, word, 3'd0, line};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Presents a read at the current falling edge, returns cycles to ack and data
  task automatic doRead(input logic [12:0] line, input logic [2:0] word,
                        output int cyc, output logic [31:0] data);
    rdReq  = 1'b1;
    rdAddr = {line, word};
    cyc = 0;
    #0.1;
    while (!rdAck && cyc < 60) begin
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    if (!rdAck) begin
      compared++; mismatched++;
      $display("FAIL R4 read timeout: actual 0 expected 1");
    end
    data = rdData;
    @(posedge clk); @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  typedef struct packed {
    logic        en;
    logic [2:0]  lim;
    logic [12:0] line;
    logic [2:0]  word;
    logic [3:0]  acc;
    logic        hit;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 13'd5,   3'd1, 4'd1, 1'b0, 4'd2},
    '{1'b0, 3'd0, 13'd5,   3'd2, 4'd1, 1'b0, 4'd2},
    '{1'b0, 3'd3, 13'd5,   3'd3, 4'd1, 1'b0, 4'd2},
    '{1'b1, 3'd0, 13'd10,  3'd0, 4'd1, 1'b0, 4'd5},
    '{1'b1, 3'd0, 13'd10,  3'd7, 4'd0, 1'b1, 4'd3},
    '{1'b1, 3'd1, 13'd20,  3'd0, 4'd2, 1'b0, 4'd6},
    '{1'b1, 3'd1, 13'd21,  3'd4, 4'd0, 1'b1, 4'd6},
    '{1'b1, 3'd1, 13'd22,  3'd0, 4'd2, 1'b0, 4'd6},
    '{1'b1, 3'd2, 13'd40,  3'd0, 4'd2, 1'b0, 4'd7},
    '{1'b1, 3'd2, 13'd41,  3'd1, 4'd1, 1'b1, 4'd7},
    '{1'b1, 3'd2, 13'd42,  3'd2, 4'd0, 1'b1, 4'd7},
    '{1'b1, 3'd3, 13'd60,  3'd0, 4'd2, 1'b0, 4'd7},
    '{1'b1, 3'd3, 13'd61,  3'd0, 4'd1, 1'b1, 4'd7},
    '{1'b1, 3'd3, 13'd62,  3'd0, 4'd1, 1'b1, 4'd7},
    '{1'b1, 3'd3, 13'd63,  3'd0, 4'd0, 1'b1, 4'd7},
    '{1'b1, 3'd6, 13'd80,  3'd0, 4'd2, 1'b0, 4'd8},
    '{1'b1, 3'd6, 13'd81,  3'd0, 4'd1, 1'b1, 4'd8},
    '{1'b1, 3'd6, 13'd82,  3'd0, 4'd1, 1'b1, 4'd8},
    '{1'b1, 3'd6, 13'd83,  3'd0, 4'd1, 1'b1, 4'd8},
    '{1'b1, 3'd7, 13'd100, 3'd0, 4'd1, 1'b0, 4'd5},
    '{1'b0, 3'd0, 13'd120, 3'd0, 4'd1, 1'b0, 4'd9},
    '{1'b1, 3'd0, 13'd120, 3'd0, 4'd1, 1'b0, 4'd9},
    '{1'b1, 3'd0, 13'd120, 3'd5, 4'd0, 1'b1, 4'd9},
    '{1'b0, 3'd0, 13'd120, 3'd5, 4'd1, 1'b0, 4'd9},
    '{1'b1, 3'd0, 13'd120, 3'd5, 4'd1, 1'b0, 4'd9},
    '{1'b1, 3'd0, 13'd200, 3'd0, 4'd1, 1'b0, 4'd10},
    '{1'b1, 3'd0, 13'd201, 3'd0, 4'd1, 1'b0, 4'd10},
    '{1'b1, 3'd0, 13'd202, 3'd0, 4'd1, 1'b0, 4'd10},
    '{1'b1, 3'd0, 13'd203, 3'd0, 4'd1, 1'b0, 4'd10},
    '{1'b1, 3'd0, 13'd200, 3'd1, 4'd0, 1'b1, 4'd10},
    '{1'b1, 3'd0, 13'd204, 3'd0, 4'd1, 1'b0, 4'd10},
    '{1'b1, 3'd0, 13'd201, 3'd0, 4'd1, 1'b0, 4'd10},
    '{1'b1, 3'd0, 13'd203, 3'd2, 4'd0, 1'b1, 4'd10}
  };

  function automatic string reqName(logic [3:0] r);
    case (r)
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic flushBuffers(logic [2:0] lim);
    bufEnable = 1'b0;
    repeat (2) @(negedge clk);
    pfLimit   = lim;
    bufEnable = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int a0, cyc;
    logic [31:0] data;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R1: quiet after reset
    check("R1", "flReq after reset", int'(flReq), 0);
    check("R1", "rdAck after reset", int'(rdAck), 0);
    check("R1", "flash accesses after reset", accCount, 0);

    for (int i = 0; i < NV; i++) begin
      bufEnable = VECS[i].en;
      pfLimit   = VECS[i].lim;
      repeat (2) @(negedge clk);
      a0 = accCount;
      doRead(VECS[i].line, VECS[i].word, cyc, data);
      check(reqName(VECS[i].req), "read data", int'(data),
            int'(expWord(VECS[i].line, VECS[i].word)));
      if (VECS[i].hit) check("R3", "hit latency", cyc, 0);
      else             check("R4", "miss latency", cyc, LAT + 1);
      settle();
      check(reqName(VECS[i].req), "flash accesses", accCount - a0, int'(VECS[i].acc));
    end

    // R11: demand miss beats the queued prefetch, which is replaced
    flushBuffers(3'd1);
    a0 = accCount;
    doRead(13'd400, 3'd0, cyc, data);
    doRead(13'd500, 3'd3, cyc, data);
    check("R11", "demand latency over prefetch", cyc, LAT + 1);
    check("R11", "demand data", int'(data), int'(expWord(13'd500, 3'd3)));
    settle();
    check("R11", "accesses (400,500,501) R13", accCount - a0, 3);
    doRead(13'd401, 3'd0, cyc, data);
    check("R11", "replaced prefetch line misses", cyc, LAT + 1);
    settle();

    // R12: read of a line in flight stalls, no second access
    flushBuffers(3'd1);
    a0 = accCount;
    doRead(13'd300, 3'd0, cyc, data);
    repeat (2) @(negedge clk);
    doRead(13'd301, 3'd6, cyc, data);
    check("R12", "stall served before fresh miss", int'(cyc > 0 && cyc <= LAT), 1);
    check("R12", "stalled data", int'(data), int'(expWord(13'd301, 3'd6)));
    settle();
    check("R12", "accesses", accCount - a0, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule